// File: doc/BRIEF.md
# NAND Register-Port Bus Serializer

This block connects a 32-bit processor register bus to an external NAND flash bus of 8 or 16 bits. It serves up to eight chip selects. Each chip select has its own register block with a configuration word and three narrow ports: command, address and data.

A processor write to a port becomes a train of NAND bus beats. The least significant part of the write goes out first. The number of beats depends on the access size and on the device width held in the configuration word. The port that was written decides whether the command-latch or the address-latch line is raised. A read of the data port collects the right number of NAND read beats and assembles them into one little-endian word.

The processor access is held off until every beat has been handshaken on the NAND side. The block then gives a one-cycle response.

Top module: `nand_port_serializer`

## Requirements
- R1: Register blocks start at byte offset 0x60, one every 0x30 bytes, with block i serving chip select i. Inside a block, +0x00..0x03 is the configuration word, +0x1C..0x1F the command port, +0x20..0x23 the address port and +0x24..0x27 the data port. Request size code 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes.
- R2: The configuration word resets to zero and can be read back with 4-byte accesses. Bits 11:10 equal to 2 select a NAND device. Bit 12 selects the device width: 0 is 8-bit, 1 is 16-bit. Bit 13 has no effect on the width.
- R3: An access narrower than 4 bytes to anything other than the three ports completes with the bad-width flag set. It reads zero and leaves the configuration word unchanged. Every other access completes with the flag clear.
- R4: Beats from the command port have CLE=1 and ALE=0. Beats from the address port have ALE=1 and CLE=0. Data-port beats have both lines low.
- R5: On an 8-bit device, a 1-, 2- or 4-byte write gives 1, 2 or 4 beats. Write data bits 7:0 go first, and NAND data bits 15:8 are driven zero.
- R6: On a 16-bit device, a 2-byte write gives one beat and a 4-byte write gives two, low halfword first. A 1-byte write gives one beat that carries write data bits 15:0.
- R7: On an 8-bit device, a 1-, 2- or 4-byte data read gives 1, 2 or 4 read beats. Beat k's NAND bits 7:0 land in result bits 8k+7:8k, and the bits above stay zero.
- R8: On a 16-bit device, a 2-byte data read gives one beat and a 4-byte read gives two, low halfword first. A 1-byte read gives one beat and returns only its low 8 bits.
- R9: When the chip select is not configured as NAND, port writes produce no beat and port reads return zero.
- R10: A beat holds valid, the strobes, CLE, ALE, chip enable and write data steady until ready is sampled high. The write strobe marks write beats and the read strobe marks read beats. Write data is zero on read beats. The request-ready pulse lasts one cycle and comes only after the last beat has completed.
- R11: Chip enable has exactly one bit set during a beat, the bit of the decoded chip select. It is all zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor access request, held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with req_ready |
| rsp_bad_width | output | 1 | Bad-width flag, valid with req_ready |
| nand_valid | output | 1 | A NAND beat is presented |
| nand_ready | input | 1 | The NAND side accepts the beat |
| nand_we | output | 1 | Write strobe |
| nand_re | output | 1 | Read strobe |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce | output | NUM_CS | One-hot chip enable |
| nand_wdata | output | 16 | Beat write data |
| nand_rdata | input | 16 | Beat read data |

## Verification
The hardest case to reach from the ports is a NAND-side stall that falls in the middle of a multi-beat train. The stall must freeze the beat without skipping or repeating a byte, and it should be seen at several beat positions. The bench lowers nand_ready on every third cycle on a free-running count that is not tied to the access length, so stalls land on different beats as the accesses go by. A second hard case is a byte access on a 16-bit device, which can only be reached after a configuration word has selected that width. The bench therefore rewrites configuration words between groups of port accesses, including one with the ignored width bit set.

// File: rtl/nps_pkg.sv
package nps_pkg;

   localparam int unsigned BLK_BASE   = 32'h60;
   localparam int unsigned BLK_STRIDE = 32'h30;
   localparam int unsigned REL_W      = 6;
   localparam int unsigned OFS_CMD    = 32'h1C;
   localparam int unsigned OFS_ADR    = 32'h20;
   localparam int unsigned OFS_DAT    = 32'h24;
   localparam int unsigned OFS_CFG_END = 32'h04;

   localparam logic [1:0] SZ_BYTE  = 2'd0;
   localparam logic [1:0] SZ_HALF  = 2'd1;
   localparam logic [1:0] SZ_WORD  = 2'd2;
   localparam logic [1:0] TYPE_NAND = 2'd2;

   typedef enum logic [1:0] {
      PORT_NONE,
      PORT_CMD,
      PORT_ADR,
      PORT_DAT
   } port_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_DONE
   } seq_state_e;

   // Index of the final beat for a device width and access size.
   function automatic logic [1:0] last_beat(input logic wide, input logic [1:0] sz);
      if (wide)                return sz[1] ? 2'd1 : 2'd0;
      else if (sz == SZ_BYTE)  return 2'd0;
      else if (sz == SZ_HALF)  return 2'd1;
      else                     return 2'd3;
   endfunction

endpackage

// File: rtl/nps_decode.sv
module nps_decode
   import nps_pkg::*;
#(
   parameter  int ADDR_W = 12,
   parameter  int NUM_CS = 8,
   localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output logic [CS_W-1:0]   cs,
   output logic              is_cfg,
   output port_e             port,
   output logic              bad_width
);

   logic             hit;
   logic [REL_W-1:0] rel;
   int unsigned      a;
   int unsigned      lo;

   always_comb begin
      hit = 1'b0;
      cs  = '0;
      rel = '0;
      a   = 32'(addr);
      lo  = 0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (a >= BLK_BASE + 32'(i) * BLK_STRIDE &&
             a <  BLK_BASE + 32'(i + 1) * BLK_STRIDE) begin
            hit = 1'b1;
            cs  = CS_W'(i);
            lo  = BLK_BASE + 32'(i) * BLK_STRIDE;
         end
      end
      if (hit) rel = REL_W'(a - lo);
   end

   always_comb begin
      is_cfg = hit && (32'(rel) < OFS_CFG_END);
      port   = PORT_NONE;
      if (hit) begin
         if (32'(rel) >= OFS_CMD && 32'(rel) < OFS_ADR)          port = PORT_CMD;
         else if (32'(rel) >= OFS_ADR && 32'(rel) < OFS_DAT)     port = PORT_ADR;
         else if (32'(rel) >= OFS_DAT && 32'(rel) < OFS_DAT + 4) port = PORT_DAT;
      end
      bad_width = (size != SZ_WORD) && (port == PORT_NONE);
   end

endmodule

// File: rtl/nps_cfg_bank.sv
module nps_cfg_bank #(
   parameter  int          NUM_CS  = 8,
   parameter  logic [31:0] CFG_RST = 32'h0,
   localparam int          CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [CS_W-1:0] sel_cs,
   input  logic [31:0]     wr_data,
   output logic [31:0]     rd_word,
   output logic            sel_is_nand,
   output logic            sel_wide
);

   logic [31:0] cfg_arr [NUM_CS];

   generate
      for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
         logic [31:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word_q <= CFG_RST;
            else if (wr_en && sel_cs == CS_W'(g))
               word_q <= wr_data;
         end
         assign cfg_arr[g] = word_q;
      end
   endgenerate

   assign rd_word     = cfg_arr[sel_cs];
   assign sel_is_nand = (rd_word[11:10] == nps_pkg::TYPE_NAND);
   assign sel_wide    = rd_word[12];

endmodule

// File: rtl/nps_sequencer.sv
module nps_sequencer
   import nps_pkg::*;
#(
   parameter  int NUM_CS = 8,
   localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [31:0]       req_wdata,
   input  port_e             dec_port,
   input  logic [CS_W-1:0]   dec_cs,
   input  logic              go_nand,
   input  logic              dev_wide,
   input  logic [31:0]       imm_rdata,
   input  logic              bad_width,
   output logic              accept,
   output logic              req_ready,
   output logic [31:0]       rsp_rdata,
   output logic              rsp_bad_width,
   output logic              nand_valid,
   input  logic              nand_ready,
   output logic              nand_we,
   output logic              nand_re,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic [NUM_CS-1:0] nand_ce,
   output logic [15:0]       nand_wdata,
   input  logic [15:0]       nand_rdata
);

   seq_state_e      state;
   logic            write_q;
   logic [1:0]      size_q;
   port_e           port_q;
   logic [CS_W-1:0] cs_q;
   logic            wide_q;
   logic [31:0]     wd_q;
   logic [31:0]     rd_q;
   logic            bad_q;
   logic [1:0]      beat_q;
   logic [1:0]      last_q;
   logic [5:0]      shamt;
   logic [31:0]     shifted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         write_q <= 1'b0;
         size_q  <= SZ_BYTE;
         port_q  <= PORT_NONE;
         cs_q    <= '0;
         wide_q  <= 1'b0;
         wd_q    <= '0;
         rd_q    <= '0;
         bad_q   <= 1'b0;
         beat_q  <= '0;
         last_q  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  write_q <= req_write;
                  size_q  <= req_size;
                  port_q  <= dec_port;
                  cs_q    <= dec_cs;
                  wide_q  <= dev_wide;
                  wd_q    <= req_wdata;
                  bad_q   <= bad_width;
                  rd_q    <= imm_rdata;
                  beat_q  <= '0;
                  last_q  <= last_beat(dev_wide, req_size);
                  state   <= go_nand ? ST_RUN : ST_DONE;
               end
            end
            ST_RUN: begin
               if (nand_ready) begin
                  if (!write_q) begin
                     if (wide_q) begin
                        if (size_q == SZ_BYTE) rd_q[7:0] <= nand_rdata[7:0];
                        else                   rd_q[{beat_q[0], 4'b0} +: 16] <= nand_rdata;
                     end else begin
                        rd_q[{beat_q, 3'b0} +: 8] <= nand_rdata[7:0];
                     end
                  end
                  if (beat_q == last_q) state <= ST_DONE;
                  else                  beat_q <= beat_q + 2'd1;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign shamt   = wide_q ? {beat_q, 4'b0} : {1'b0, beat_q, 3'b0};
   assign shifted = wd_q >> shamt;

   assign accept        = (state == ST_IDLE);
   assign req_ready     = (state == ST_DONE);
   assign rsp_rdata     = rd_q;
   assign rsp_bad_width = req_ready & bad_q;
   assign nand_valid    = (state == ST_RUN);
   assign nand_we       = nand_valid &  write_q;
   assign nand_re       = nand_valid & ~write_q;
   assign nand_cle      = nand_valid && (port_q == PORT_CMD);
   assign nand_ale      = nand_valid && (port_q == PORT_ADR);
   assign nand_ce       = nand_valid ? (NUM_CS'(1) << cs_q) : '0;
   assign nand_wdata    = !nand_we ? 16'h0 :
                          wide_q   ? shifted[15:0] : {8'h00, shifted[7:0]};

   AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale)); // R4
   AST_CE_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
      nand_valid |-> $countones(nand_ce) == 1); // R11
   AST_CE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_valid |-> nand_ce == '0); // R11
   AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      nand_valid && !nand_ready |=> nand_valid && $stable(nand_wdata) &&
      $stable(nand_cle) && $stable(nand_ale) && $stable(nand_ce) && $stable(nand_we)); // R10
   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready); // R10
   AST_NO_BEAT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !nand_valid && !nand_we && !nand_re); // R10

endmodule

// File: rtl/nand_port_serializer.sv
module nand_port_serializer
   import nps_pkg::*;
#(
   parameter  int          ADDR_W  = 12,
   parameter  int          NUM_CS  = 8,
   parameter  logic [31:0] CFG_RST = 32'h0,
   localparam int          CS_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [31:0]       req_wdata,
   output logic              req_ready,
   output logic [31:0]       rsp_rdata,
   output logic              rsp_bad_width,
   output logic              nand_valid,
   input  logic              nand_ready,
   output logic              nand_we,
   output logic              nand_re,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic [NUM_CS-1:0] nand_ce,
   output logic [15:0]       nand_wdata,
   input  logic [15:0]       nand_rdata
);

   localparam longint unsigned SPAN = longint'(BLK_BASE) + longint'(NUM_CS) * longint'(BLK_STRIDE);

   generate
      if (NUM_CS < 1 || NUM_CS > 8) begin : g_bad_num_cs
         $error("NUM_CS must lie in 1..8");
      end
      if (ADDR_W > 32 || (64'd1 << ADDR_W) < SPAN) begin : g_bad_addr_w
         $error("ADDR_W cannot cover every register block");
      end
   endgenerate

   logic [CS_W-1:0] dec_cs;
   logic            dec_is_cfg;
   port_e           dec_port;
   logic            dec_bad;
   logic            accept;
   logic            cfg_we;
   logic [31:0]     cfg_word;
   logic            cfg_is_nand;
   logic            cfg_wide;
   logic            go_nand;
   logic [31:0]     imm_rdata;

   nps_decode #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_decode (
      .addr      (req_addr),
      .size      (req_size),
      .cs        (dec_cs),
      .is_cfg    (dec_is_cfg),
      .port      (dec_port),
      .bad_width (dec_bad)
   );

   assign cfg_we = accept && req_valid && req_write && dec_is_cfg && !dec_bad;

   nps_cfg_bank #(.NUM_CS(NUM_CS), .CFG_RST(CFG_RST)) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (cfg_we),
      .sel_cs      (dec_cs),
      .wr_data     (req_wdata),
      .rd_word     (cfg_word),
      .sel_is_nand (cfg_is_nand),
      .sel_wide    (cfg_wide)
   );

   assign go_nand   = (dec_port != PORT_NONE) && cfg_is_nand;
   assign imm_rdata = (dec_is_cfg && !req_write && !dec_bad) ? cfg_word : 32'h0;

   nps_sequencer #(.NUM_CS(NUM_CS)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_write     (req_write),
      .req_size      (req_size),
      .req_wdata     (req_wdata),
      .dec_port      (dec_port),
      .dec_cs        (dec_cs),
      .go_nand       (go_nand),
      .dev_wide      (cfg_wide),
      .imm_rdata     (imm_rdata),
      .bad_width     (dec_bad),
      .accept        (accept),
      .req_ready     (req_ready),
      .rsp_rdata     (rsp_rdata),
      .rsp_bad_width (rsp_bad_width),
      .nand_valid    (nand_valid),
      .nand_ready    (nand_ready),
      .nand_we       (nand_we),
      .nand_re       (nand_re),
      .nand_cle      (nand_cle),
      .nand_ale      (nand_ale),
      .nand_ce       (nand_ce),
      .nand_wdata    (nand_wdata),
      .nand_rdata    (nand_rdata)
   );

   AST_NARROW_NO_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      accept && req_valid && dec_bad |=> !nand_valid); // R3

endmodule

// File: tb/nand_port_serializer_bench.sv
module nand_port_serializer_bench;
   import nps_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 12;
   localparam int NUM_CS     = 8;
   localparam logic [15:0] RD_STEP = 16'h1357;

   typedef struct packed {
      logic        we;
      logic        re;
      logic        cle;
      logic        ale;
      logic [7:0]  ce;
      logic [15:0] wd;
   } beat_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr  = '0;
   logic [1:0]        req_size  = '0;
   logic [31:0]       req_wdata = '0;
   logic              req_ready;
   logic [31:0]       rsp_rdata;
   logic              rsp_bad_width;
   logic              nand_valid;
   logic              nand_ready = 1'b0;
   logic              nand_we, nand_re, nand_cle, nand_ale;
   logic [NUM_CS-1:0] nand_ce;
   logic [15:0]       nand_wdata;
   logic [15:0]       nand_rdata = 16'h0A0B;
   logic [15:0]       model_rd   = 16'h0A0B;

   beat_t exp_q[$];
   int    n_tests = 0;
   int    n_fail  = 0;
   int    rdy_cnt = 0;
   bit    adv_pending = 1'b0;
   string cur_req = "R10";

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_port_serializer #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_nand_port_serializer (
      .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_size, .req_wdata,
      .req_ready, .rsp_rdata, .rsp_bad_width, .nand_valid, .nand_ready,
      .nand_we, .nand_re, .nand_cle, .nand_ale, .nand_ce, .nand_wdata, .nand_rdata
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Monitor: pops the expected beat whenever a handshake is about to happen.
   always @(negedge clk) begin
      if (rst_n) begin
         if (adv_pending) nand_rdata = nand_rdata + RD_STEP;
         adv_pending = 1'b0;
         rdy_cnt++;
         nand_ready = (rdy_cnt % 3) != 1;
         if (nand_valid && nand_ready) begin
            beat_t act;
            act = {nand_we, nand_re, nand_cle, nand_ale, nand_ce, nand_wdata};
            adv_pending = nand_re;
            if (exp_q.size() == 0) begin
               check(1'b0, "R10 unexpected beat", 32'(act), 32'h0);
            end else begin
               beat_t exp;
               exp = exp_q.pop_front();
               check(act == exp, cur_req, 32'(act), 32'(exp));
            end
         end
      end
   end

   function automatic logic [ADDR_W-1:0] blk(input int cs, input int ofs);
      return ADDR_W'(32'h60 + cs * 32'h30 + ofs);
   endfunction

   task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, output logic [31:0] rd, output logic bad);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
      forever begin
         @(negedge clk);
         if (req_ready) break;
      end
      rd = rsp_rdata;
      bad = rsp_bad_width;
      req_valid = 1'b0;
      check(exp_q.size() == 0, "R10 beats outstanding at ready", 32'(exp_q.size()), 32'h0);
   endtask

   task automatic push_wr(input int cs, input bit cle, input bit ale, input bit wide,
                          input logic [1:0] sz, input logic [31:0] wd);
      int n;
      n = wide ? (sz == SZ_WORD ? 2 : 1) : (sz == SZ_BYTE ? 1 : sz == SZ_HALF ? 2 : 4);
      for (int k = 0; k < n; k++) begin
         beat_t b;
         b.we = 1'b1; b.re = 1'b0; b.cle = cle; b.ale = ale;
         b.ce = 8'(1 << cs);
         b.wd = wide ? wd[16*k +: 16] : {8'h00, wd[8*k +: 8]};
         exp_q.push_back(b);
      end
   endtask

   task automatic push_rd(input int cs, input bit wide, input logic [1:0] sz, output logic [31:0] exp);
      int n;
      exp = '0;
      n = wide ? (sz == SZ_WORD ? 2 : 1) : (sz == SZ_BYTE ? 1 : sz == SZ_HALF ? 2 : 4);
      for (int k = 0; k < n; k++) begin
         beat_t b;
         b.we = 1'b0; b.re = 1'b1; b.cle = 1'b0; b.ale = 1'b0;
         b.ce = 8'(1 << cs); b.wd = 16'h0;
         exp_q.push_back(b);
         if (wide) exp[16*k +: 16] = model_rd;
         else      exp[8*k +: 8]   = model_rd[7:0];
         model_rd = model_rd + RD_STEP;
      end
      if (wide && sz == SZ_BYTE) exp = exp & 32'hFF;
   endtask

   task automatic wr_chk(input string req, input int cs, input int ofs, input bit cle, input bit ale,
                         input bit wide, input logic [1:0] sz, input logic [31:0] wd);
      logic [31:0] rd;
      logic bad;
      cur_req = req;
      push_wr(cs, cle, ale, wide, sz, wd);
      access(1'b1, blk(cs, ofs), sz, wd, rd, bad);
      check(bad == 1'b0, req, 32'(bad), 32'h0);
   endtask

   task automatic rd_chk(input string req, input int cs, input bit wide, input logic [1:0] sz);
      logic [31:0] rd, exp;
      logic bad;
      cur_req = req;
      push_rd(cs, wide, sz, exp);
      access(1'b0, blk(cs, 32'h24), sz, 32'h0, rd, bad);
      check(rd == exp, req, rd, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL R10 watchdog expired: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state (R10, R11)
      check(req_ready == 1'b0 && nand_valid == 1'b0, "R10 reset idle", {30'h0, req_ready, nand_valid}, 32'h0);
      check(nand_ce == '0, "R11 reset ce", 32'(nand_ce), 32'h0);

      // R2: config resets to zero
      access(1'b0, blk(0, 0), SZ_WORD, 32'h0, rd, bad);
      check(rd == 32'h0 && !bad, "R2 cfg reset", rd, 32'h0);

      // R3: narrow access to config is bad width and has no effect
      access(1'b1, blk(3, 0), SZ_HALF, 32'h0000_0800, rd, bad);
      check(bad == 1'b1, "R3 narrow cfg write flagged", 32'(bad), 32'h1);
      access(1'b0, blk(3, 0), SZ_WORD, 32'h0, rd, bad);
      check(rd == 32'h0, "R3 cfg unchanged", rd, 32'h0);
      access(1'b0, blk(3, 0), SZ_BYTE, 32'h0, rd, bad);
      check(bad == 1'b1 && rd == 32'h0, "R3 narrow read flagged", {rd[30:0], bad}, 32'h1);
      access(1'b0, ADDR_W'(32'h10), SZ_WORD, 32'h0, rd, bad);
      check(bad == 1'b0 && rd == 32'h0, "R3 word read outside blocks", {rd[30:0], bad}, 32'h0);
      cur_req = "R3 narrow write to cs3 command while cfg zero";
      access(1'b1, blk(3, 32'h1C), SZ_BYTE, 32'hFF, rd, bad);
      check(bad == 1'b0, "R3 port narrow not flagged", 32'(bad), 32'h0);

      // R2: cs2 as NAND 8-bit, bit 13 set must not widen it
      access(1'b1, blk(2, 0), SZ_WORD, 32'h0000_2800, rd, bad);
      access(1'b0, blk(2, 0), SZ_WORD, 32'h0, rd, bad);
      check(rd == 32'h0000_2800, "R2 cfg readback", rd, 32'h0000_2800);

      // R4/R5: command, address, data on 8-bit device
      wr_chk("R4 R5 command byte", 2, 32'h1C, 1'b1, 1'b0, 1'b0, SZ_BYTE, 32'h0000_00A5);
      wr_chk("R4 R5 address word", 2, 32'h20, 1'b0, 1'b1, 1'b0, SZ_WORD, 32'h1122_3344);
      wr_chk("R5 data half", 2, 32'h24, 1'b0, 1'b0, 1'b0, SZ_HALF, 32'h0000_BEEF);
      wr_chk("R1 command port upper byte lane", 2, 32'h1E, 1'b1, 1'b0, 1'b0, SZ_BYTE, 32'h0000_0070);
      wr_chk("R1 data port at +0x27", 2, 32'h27, 1'b0, 1'b0, 1'b0, SZ_BYTE, 32'h0000_0031);

      // R7: 8-bit reads
      rd_chk("R7 read word 8-bit", 2, 1'b0, SZ_WORD);
      rd_chk("R7 read byte 8-bit", 2, 1'b0, SZ_BYTE);
      rd_chk("R7 read half 8-bit", 2, 1'b0, SZ_HALF);

      // R6/R8: cs5 as NAND 16-bit
      access(1'b1, blk(5, 0), SZ_WORD, 32'h0000_1800, rd, bad);
      wr_chk("R6 data word 16-bit", 5, 32'h24, 1'b0, 1'b0, 1'b1, SZ_WORD, 32'hCAFE_F00D);
      wr_chk("R6 address half 16-bit", 5, 32'h20, 1'b0, 1'b1, 1'b1, SZ_HALF, 32'h0000_4321);
      wr_chk("R6 command byte 16-bit", 5, 32'h1C, 1'b1, 1'b0, 1'b1, SZ_BYTE, 32'h5A5A_12AB);
      rd_chk("R8 read word 16-bit", 5, 1'b1, SZ_WORD);
      rd_chk("R8 read half 16-bit", 5, 1'b1, SZ_HALF);
      rd_chk("R8 read byte 16-bit", 5, 1'b1, SZ_BYTE);

      // R9: non-NAND chip selects
      cur_req = "R9 no beat for non-NAND";
      access(1'b1, blk(6, 32'h24), SZ_WORD, 32'hDEAD_BEEF, rd, bad);
      access(1'b0, blk(6, 32'h24), SZ_WORD, 32'h0, rd, bad);
      check(rd == 32'h0, "R9 NOR read zero", rd, 32'h0);
      access(1'b1, blk(6, 0), SZ_WORD, 32'h0000_0400, rd, bad);
      access(1'b1, blk(6, 32'h1C), SZ_BYTE, 32'h0000_0090, rd, bad);
      access(1'b0, blk(6, 32'h24), SZ_HALF, 32'h0, rd, bad);
      check(rd == 32'h0, "R9 type-1 read zero", rd, 32'h0);

      // R11: last chip select
      access(1'b1, blk(7, 0), SZ_WORD, 32'h0000_0800, rd, bad);
      wr_chk("R11 cs7 address", 7, 32'h20, 1'b0, 1'b1, 1'b0, SZ_HALF, 32'h0000_9876);
      rd_chk("R11 cs7 read", 7, 1'b0, SZ_WORD);

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R10 queue drained", 32'(exp_q.size()), 32'h0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule